// File: doc/BRIEF.md
# Octal Output Latch with Fault Blanking

This block keeps the on/off command for eight low-side output channels and drives one active-high gate-enable per channel. A command word arrives together with a one-cycle load strobe, normally issued when a serial frame closes. In the command word a 0 bit asks for the channel to be on and a 1 bit asks for it to be off. The outputs follow the new word in the cycle after the strobe.

Each channel also has a digital over-voltage fault flag. Every load starts a blanking interval of `BLANK_CYC` clock cycles, so that inrush currents can settle. During that interval faults are ignored. Once the interval has run out, any channel that is on and sees its fault flag is switched off. Its bit in a sticky fault status word is set, and the channel stays off until a later load turns it on again. A load that arrives while blanking is still running starts the interval again from the beginning.

The blanking timer is a three-state machine. IDLE is the state after reset, when no load has yet been seen. BLANK is the state while the interval runs. ARMED is the state once it has expired. Its transitions are START (IDLE or ARMED to BLANK on a load), RESTART (BLANK to BLANK on a load), EXPIRE (BLANK to ARMED when the count ends) and HOLD (all other cases). Each channel is also a three-state machine. OFF means commanded off. ON means commanded on. TRIPPED means switched off by a fault. Its transitions are LOAD_ON and LOAD_OFF, taken from any state on a load, and TRIP, taken from ON on a fault outside blanking.

Top module: `octal_out_latch`

## Requirements
- R1: After reset all gate enables are 0, the fault status is 0, the timer is IDLE, and faults have no effect.
- R2: On a cycle with `cmd_load` high, bit i of `gate_en` becomes 1 when `cmd_word` bit i is 0, and becomes 0 when that bit is 1. The new value is visible after that clock edge.
- R3: The load edge is followed by `BLANK_CYC` clock edges. At none of them does a fault change `gate_en` or `fault_stat`.
- R4: At any later edge without a load, a channel that is on and has its `fault_in` bit at 1 turns off at that edge.
- R5: A fault shutdown changes only the faulted channel. Every other gate enable keeps its value.
- R6: A channel that a fault turned off stays off, even after its fault flag clears, until a load with a 0 bit for it.
- R7: A load while blanking is running restarts the full `BLANK_CYC` interval from that load.
- R8: `fault_stat` bit i is set when channel i is shut down by a fault. It stays set, and the whole word clears on the next load.
- R9: A fault flag on a channel that is off changes neither its gate enable nor its status bit.
- R10: When a load and an active fault occur at the same edge, the load wins and the fault has no effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | 8 | Command word, 0 = channel on, 1 = channel off |
| cmd_load | input | 1 | One-cycle strobe that loads `cmd_word` |
| fault_in | input | 8 | Per-channel over-voltage fault flags, active high |
| gate_en | output | 8 | Per-channel gate enables, active high |
| fault_stat | output | 8 | Sticky record of channels shut down by a fault |

## Verification
The assertions take the fault flags and the load strobe to be synchronous to `clk`, with their values settled before each rising edge. They also assume `BLANK_CYC` is at least 1. A load that lasts several cycles is legal: each of its cycles counts as a fresh load that restarts blanking. The bench changes every input only on falling clock edges. It runs the block with a short blanking interval, so that expiry, restarts inside the interval, and a load coinciding with a fault are all reached many times. Every cycle it compares the block against a behavioural model that holds a plain integer countdown.

// File: rtl/oll_pkg.sv
package oll_pkg;

    typedef enum logic [1:0] {
        BT_IDLE  = 2'd0,
        BT_BLANK = 2'd1,
        BT_ARMED = 2'd2
    } blank_state_e;

    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_ON      = 2'd1,
        CH_TRIPPED = 2'd2
    } chan_state_e;

endpackage

// File: rtl/oll_blank_timer.sv
module oll_blank_timer
    import oll_pkg::*;
#(
    parameter int BLANK_CYC = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic blanking
);
    localparam int CW = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
    localparam logic [CW-1:0] CNT_START = CW'(BLANK_CYC - 1);

    blank_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // next-state logic: START, RESTART, EXPIRE, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BT_IDLE:  if (load) state_d = BT_BLANK;
            BT_BLANK: begin
                if (load)            state_d = BT_BLANK;
                else if (cnt_q == '0) state_d = BT_ARMED;
            end
            BT_ARMED: if (load) state_d = BT_BLANK;
            default:  state_d = BT_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BT_IDLE;
        else        state_q <= state_d;
    end

    // interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (load)                           cnt_q <= CNT_START;
        else if (state_q == BT_BLANK && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // outputs
    always_comb begin
        blanking = (state_q == BT_BLANK);
    end

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == BT_BLANK && cnt_q == CNT_START));

    assert_expire_only_from_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BT_BLANK && cnt_q != '0 && !load) |=> state_q == BT_BLANK);

    assert_idle_until_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BT_IDLE && !load) |=> state_q == BT_IDLE);

endmodule

// File: rtl/oll_chan_cell.sv
module oll_chan_cell
    import oll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic cmd_bit,
    input  logic fault,
    input  logic blanking,
    output logic gate,
    output logic tripped
);
    chan_state_e st_q, st_d;

    // next-state logic: LOAD_ON, LOAD_OFF, TRIP
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d = cmd_bit ? CH_OFF : CH_ON;
        end else begin
            unique case (st_q)
                CH_OFF:     st_d = CH_OFF;
                CH_ON:      if (fault && !blanking) st_d = CH_TRIPPED;
                CH_TRIPPED: st_d = CH_TRIPPED;
                default:    st_d = CH_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        gate    = (st_q == CH_ON);
        tripped = (st_q == CH_TRIPPED);
    end

    assert_no_trip_in_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (blanking && !load && st_q == CH_ON) |=> st_q == CH_ON);

    assert_off_ignores_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CH_ON && !load) |=> st_q == $past(st_q));

    assert_trip_when_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_ON && fault && !blanking && !load) |=> st_q == CH_TRIPPED);

endmodule

// File: rtl/octal_out_latch.sv
module octal_out_latch
    import oll_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int BLANK_CYC = 8000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmd_word,
    input  logic           cmd_load,
    input  logic [NCH-1:0] fault_in,
    output logic [NCH-1:0] gate_en,
    output logic [NCH-1:0] fault_stat
);
    logic blanking;

    oll_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_load),
        .blanking (blanking)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        oll_chan_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cmd_load),
            .cmd_bit  (cmd_word[i]),
            .fault    (fault_in[i]),
            .blanking (blanking),
            .gate     (gate_en[i]),
            .tripped  (fault_stat[i])
        );
    end

    assert_load_applies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |=> gate_en == ~$past(cmd_word));

    assert_load_clears_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |=> fault_stat == '0);

    assert_no_turn_on_without_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_load |=> (gate_en & ~$past(gate_en)) == '0);

    assert_only_faulted_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_load |=> ((gate_en ^ $past(gate_en)) & ~$past(fault_in)) == '0);

    assert_stat_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_load |=> (fault_stat & $past(fault_stat)) == $past(fault_stat));

endmodule

// File: tb/sim_octal_out_latch.sv
`timescale 1ns/1ps
module sim_octal_out_latch;
    localparam int B = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cmd_word = 8'hFF;
    logic       cmd_load = 1'b0;
    logic [7:0] fault_in = 8'h00;
    logic [7:0] gate_en, fault_stat;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] m_gate = 8'h00;
    logic [7:0] m_stat = 8'h00;
    logic [7:0] kill;
    int         m_left = 0;

    always #10 clk = ~clk;

    octal_out_latch #(.NCH(8), .BLANK_CYC(B)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_load(cmd_load),
        .fault_in(fault_in), .gate_en(gate_en), .fault_stat(fault_stat)
    );

    // behavioural reference: integer countdown of remaining blanked edges
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_gate = 8'h00; m_stat = 8'h00; m_left = 0;
        end else if (cmd_load) begin
            m_gate = ~cmd_word; m_stat = 8'h00; m_left = B;
        end else if (m_left > 0) begin
            m_left = m_left - 1;
        end else begin
            kill   = m_gate & fault_in;
            m_gate = m_gate & ~kill;
            m_stat = m_stat | kill;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (gate_en !== m_gate) begin
                failures++;
                $display("FAIL R4 model gate_en actual=%h expected=%h t=%0t", gate_en, m_gate, $time);
            end
            checks++;
            if (fault_stat !== m_stat) begin
                failures++;
                $display("FAIL R8 model fault_stat actual=%h expected=%h t=%0t", fault_stat, m_stat, $time);
            end
        end
    end

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(logic [7:0] w);
        cmd_word = w; cmd_load = 1'b1;
        tick();
        cmd_load = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, and faults without any load do nothing
        check("R1 gate_en in reset", gate_en, 8'h00);
        check("R1 fault_stat in reset", fault_stat, 8'h00);
        rst_n = 1'b1;
        fault_in = 8'hFF;
        repeat (4) tick();
        check("R1 gate_en after reset with faults", gate_en, 8'h00);
        check("R1 fault_stat after reset with faults", fault_stat, 8'h00);
        fault_in = 8'h00;

        // R2: active-low command
        do_load(8'hA5);
        check("R2 load A5", gate_en, 8'h5A);
        fault_in = 8'h0F;
        repeat (B) tick();
        check("R3 gate held through blanking", gate_en, 8'h5A);
        check("R3 stat held through blanking", fault_stat, 8'h00);
        tick();
        check("R4 R5 trip after expiry", gate_en, 8'h50);
        check("R8 R9 stat records only on channels", fault_stat, 8'h0A);
        fault_in = 8'h00;
        repeat (5) tick();
        check("R6 tripped stays off", gate_en, 8'h50);
        check("R8 stat sticky", fault_stat, 8'h0A);

        do_load(8'h00);
        check("R6 reload turns back on", gate_en, 8'hFF);
        check("R8 stat cleared by load", fault_stat, 8'h00);

        // R7: reload three edges before expiry restarts the window
        repeat (B - 3) tick();
        do_load(8'h00);
        fault_in = 8'h01;
        repeat (B) tick();
        check("R7 restarted blanking holds", gate_en, 8'hFF);
        tick();
        check("R7 trip after restarted window", gate_en, 8'hFE);

        // R10: load and fault at the same edge while armed
        fault_in = 8'h80;
        cmd_word = 8'h7F; cmd_load = 1'b1;
        tick();
        cmd_load = 1'b0;
        check("R10 load wins over fault", gate_en, 8'h80);
        check("R10 stat clear after load", fault_stat, 8'h00);
        fault_in = 8'h00;

        // R2 second pattern
        do_load(8'h3C);
        check("R2 load 3C", gate_en, 8'hC3);

        // mixed random traffic, compared every cycle
        for (int n = 0; n < 3000; n++) begin
            cmd_load = ($urandom_range(0, 29) == 0);
            cmd_word = 8'($urandom);
            if ($urandom_range(0, 3) == 0) fault_in = 8'($urandom);
            tick();
        end
        cmd_load = 1'b0;
        tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule